// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block divides the system clock down to a periodic one-clock strobe. The serial transmit and receive logic uses the strobe as its oversampling tick, and sixteen ticks make one bit time. The division ratio is a fixed-point number. It has an integer part of `INT_W` bits and a fractional part of `FRAC_W` bits, which by default are 16 and 6 bits, 22 bits in all. Because of the fraction, the average tick spacing can fall between two whole clock counts. Standard baud rates can then be reached from a clock that is not a convenient multiple of them.

Each part of the divisor has its own data input and load strobe. A load only updates a pending copy of that part. The counter reads the pending pair only at an interval boundary, so a divisor change never cuts short or stretches an interval already running. Each fractional step is added to a modulo-2^FRAC_W phase accumulator. Every wrap of the accumulator adds one clock to the interval that starts at that boundary. An integer part of zero parks the generator after the interval in progress has ended. The phase is then cleared, and the generator restarts as soon as a nonzero integer is pending.

Top module: `frac_tick_gen`

## Requirements
- R1: While reset is asserted, and after its release with the reset divisor parameters at their default of zero, `tick_o` stays low.
- R2: With fraction F = 0 and integer I ≥ 1, the rising ticks are exactly I clocks apart. When I = 1, `tick_o` stays high.
- R3: Intervals are numbered k = 1, 2, ... from the start of ticking. Interval k lasts I + floor(k·F/64) − floor((k−1)·F/64) clocks, for FRAC_W = 6. Any 64 consecutive intervals from the start therefore total 64·I + F clocks.
- R4: When I ≥ 2, each tick is high for exactly one clock.
- R5: Suppose the generator is idle and a nonzero integer is loaded with its strobe high in cycle n. The first tick is then high in cycle n + I + 2, and the phase accumulator starts from zero.
- R6: A load during an interval does not change the length of that interval. The new value governs only the intervals that start at later boundaries.
- R7: When the integer part zero is loaded, the current interval still ends with its tick. After that no tick occurs until a nonzero integer is loaded.
- R8: The integer and fraction loads are independent. Loading only the fraction keeps the integer part, and the accumulator keeps its phase. For example, with I = 6, changing F from 0 to 32 gives intervals of 6, 7, 6, 7 clocks after the first new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_div_i | input | INT_W | Integer part of the divisor |
| int_load_i | input | 1 | Captures `int_div_i` into the pending integer |
| frac_div_i | input | FRAC_W | Fractional part of the divisor, in units of 2^-FRAC_W |
| frac_load_i | input | 1 | Captures `frac_div_i` into the pending fraction |
| tick_o | output | 1 | One-clock sampling tick |

## Verification
A wrong phase accumulator shows up as an interval one clock too long or too short. The error appears within the first 64 intervals after a start, and the 64-interval sum from R3 shows it as a drift. A counter that reloads at the wrong moment shows up in the very next tick-to-tick gap, either because a divisor was adopted mid-interval or because the generator failed to park after a zero load. The sweep covers every fraction value at three integer values, so each carry pattern reaches the tick output.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

   localparam int FTG_DEF_INT_W  = 16;
   localparam int FTG_DEF_FRAC_W = 6;

   // Decoded condition of the interval counter.
   typedef enum logic [1:0] {
      FTG_IDLE  = 2'd0,   // counter parked at zero, no ticks
      FTG_COUNT = 2'd1,   // inside an interval
      FTG_EDGE  = 2'd2    // last clock of an interval
   } ftg_state_e;

endpackage

// File: rtl/ftg_shadow.sv
module ftg_shadow #(
   parameter int W   = 16,
   parameter int RST = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] RST_V = W'(RST);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= RST_V;
      else if (ld)
         q <= d;
   end

endmodule

// File: rtl/ftg_phase.sv
module ftg_phase #(
   parameter int FRAC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              clear,
   input  logic [FRAC_W-1:0] frac,
   output logic              carry,
   output logic [FRAC_W-1:0] acc
);

   localparam int SUM_W = FRAC_W + 1;

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum   = {1'b0, acc} + {1'b0, frac};
      carry = sum[FRAC_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc <= '0;
      else if (clear)
         acc <= '0;
      else if (advance)
         acc <= sum[FRAC_W-1:0];
   end

endmodule

// File: rtl/ftg_interval.sv
module ftg_interval
   import ftg_pkg::*;
#(
   parameter int INT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INT_W-1:0] int_div,
   input  logic             carry,
   output ftg_state_e       state,
   output logic [INT_W:0]   cnt,
   output logic             tick
);

   localparam int CNT_W = INT_W + 1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] reload_val;

   always_comb begin
      if (cnt == '0)
         state = FTG_IDLE;
      else if (cnt == ONE)
         state = FTG_EDGE;
      else
         state = FTG_COUNT;
   end

   // Length of the interval that begins at this boundary.
   always_comb begin
      if (int_div == '0)
         reload_val = '0;
      else
         reload_val = {1'b0, int_div} + CNT_W'(carry);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         if (state == FTG_COUNT)
            cnt <= cnt - ONE;
         else
            cnt <= reload_val;
         tick <= (state == FTG_EDGE);
      end
   end

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
   import ftg_pkg::*;
#(
   parameter int INT_W    = FTG_DEF_INT_W,
   parameter int FRAC_W   = FTG_DEF_FRAC_W,
   parameter int RST_INT  = 0,
   parameter int RST_FRAC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INT_W-1:0]  int_div_i,
   input  logic              int_load_i,
   input  logic [FRAC_W-1:0] frac_div_i,
   input  logic              frac_load_i,
   output logic              tick_o
);

   localparam int CNT_W = INT_W + 1;

   // Elaboration-time parameter checks.
   if (INT_W < 2 || INT_W > 30) begin : g_bad_int_w
      $error("frac_tick_gen: INT_W must lie in 2..30");
   end
   if (FRAC_W < 1 || FRAC_W > 16) begin : g_bad_frac_w
      $error("frac_tick_gen: FRAC_W must lie in 1..16");
   end
   if (RST_INT < 0 || RST_INT >= (1 << INT_W)) begin : g_bad_rst_int
      $error("frac_tick_gen: RST_INT does not fit INT_W");
   end
   if (RST_FRAC < 0 || RST_FRAC >= (1 << FRAC_W)) begin : g_bad_rst_frac
      $error("frac_tick_gen: RST_FRAC does not fit FRAC_W");
   end

   logic [INT_W-1:0]  pend_int;
   logic [FRAC_W-1:0] pend_frac;
   logic [FRAC_W-1:0] acc_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              carry;
   logic              advance;
   logic              clear;
   ftg_state_e        state;

   ftg_shadow #(.W(INT_W), .RST(RST_INT)) i_int_shadow (
      .clk (clk),
      .rst_n (rst_n),
      .ld  (int_load_i),
      .d   (int_div_i),
      .q   (pend_int)
   );

   ftg_shadow #(.W(FRAC_W), .RST(RST_FRAC)) i_frac_shadow (
      .clk (clk),
      .rst_n (rst_n),
      .ld  (frac_load_i),
      .d   (frac_div_i),
      .q   (pend_frac)
   );

   // The phase steps once per started interval and clears when parking.
   always_comb begin
      advance = (state != FTG_COUNT) && (pend_int != '0);
      clear   = (state == FTG_EDGE)  && (pend_int == '0);
   end

   ftg_phase #(.FRAC_W(FRAC_W)) i_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .clear   (clear),
      .frac    (pend_frac),
      .carry   (carry),
      .acc     (acc_q)
   );

   ftg_interval #(.INT_W(INT_W)) i_interval (
      .clk     (clk),
      .rst_n   (rst_n),
      .int_div (pend_int),
      .carry   (carry),
      .state   (state),
      .cnt     (cnt_q),
      .tick    (tick_o)
   );

endmodule

// File: rtl/ftg_checker.sv
module ftg_checker #(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [INT_W:0]    cnt,
   input logic [INT_W-1:0]  pend_int,
   input logic [FRAC_W-1:0] acc
);

   localparam int CNT_W = INT_W + 1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] pend_ext;
   assign pend_ext = {1'b0, pend_int};

   // R2
   tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick) |-> ($past(cnt) == ONE));

   // R4
   tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt != ONE) |=> !tick);

   // R3
   stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt <= ONE && pend_int != '0) |=>
         (cnt == $past(pend_ext) || cnt == $past(pend_ext) + ONE));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > ONE) |=> (cnt == $past(cnt) - ONE));

   // R7
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == ONE && pend_int == '0) |=> (cnt == '0));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |=> !tick);

   // R5
   acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> (acc == '0));

endmodule

bind frac_tick_gen ftg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_ftg_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick_o),
   .cnt      (cnt_q),
   .pend_int (pend_int),
   .acc      (acc_q)
);

// File: tb/test_frac_tick_gen.sv
`timescale 1ns/1ps
module test_frac_tick_gen;

   localparam int INT_W  = 16;
   localparam int FRAC_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [INT_W-1:0]  int_div = '0;
   logic              int_load = 1'b0;
   logic [FRAC_W-1:0] frac_div = '0;
   logic              frac_load = 1'b0;
   logic              tick;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   frac_tick_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_frac_tick_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .int_div_i   (int_div),
      .int_load_i  (int_load),
      .frac_div_i  (frac_div),
      .frac_load_i (frac_load),
      .tick_o      (tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(output logic t);
      @(negedge clk);
      t = tick;
   endtask

   task automatic load(input int iv, input bit li, input int fv, input bit lf, output logic t);
      int_div   = INT_W'(iv);
      int_load  = li;
      frac_div  = FRAC_W'(fv);
      frac_load = lf;
      step(t);
      int_load  = 1'b0;
      frac_load = 1'b0;
   endtask

   // Negedges until tick is seen high, or -1 after limit.
   task automatic wait_tick(input int limit, output int gap);
      logic t;
      gap = 0;
      do begin
         step(t);
         gap++;
      end while (!t && gap < limit);
      if (!t) gap = -1;
   endtask

   task automatic go_idle(input int drain);
      logic t;
      load(0, 1'b1, 0, 1'b0, t);
      repeat (drain) step(t);
   endtask

   initial begin
      logic t;
      int   g;
      int   g2;
      int   total;
      int   expv;
      int   ivals[3];
      ivals = '{1, 2, 5};

      // R1: tick low in reset and while idle after it
      repeat (5) @(negedge clk);
      check(tick == 1'b0, "R1 in reset", int'(tick), 0);
      rst_n = 1'b1;
      wait_tick(40, g);
      check(g == -1, "R1 idle after reset", g, -1);

      // R2 R3 R4 R5: sweep of every fraction at three integers
      foreach (ivals[ii]) begin
         for (int f = 0; f < 64; f++) begin
            int iv;
            iv = ivals[ii];
            go_idle(iv + 4);
            load(iv, 1'b1, f, 1'b1, t);
            wait_tick(iv + 6, g);
            check(g == iv + 1, "R5 start latency", g, iv + 1);
            total = iv;
            for (int k = 2; k <= 64; k++) begin
               expv = iv + (k * f) / 64 - ((k - 1) * f) / 64;
               wait_tick(iv + 4, g);
               if (f == 0)
                  check(g == expv, "R2 integer gap", g, expv);
               else
                  check(g == expv, "R3 fractional gap", g, expv);
               if (iv >= 2)
                  check(g >= 2, "R4 one-clock tick", g, 2);
               total += g;
            end
            check(total == 64 * iv + f, "R3 64-interval total", total, 64 * iv + f);
         end
      end

      // R6: mid-interval integer change adopted at the boundary
      go_idle(12);
      load(8, 1'b1, 0, 1'b1, t);
      wait_tick(20, g);
      check(g == 9, "R6 start", g, 9);
      step(t); step(t); step(t);
      load(3, 1'b1, 0, 1'b0, t);
      wait_tick(20, g2);
      check(4 + g2 == 8, "R6 running interval kept", 4 + g2, 8);
      wait_tick(20, g);
      check(g == 3, "R6 new interval", g, 3);
      wait_tick(20, g);
      check(g == 3, "R6 new interval again", g, 3);

      // R7: zero integer parks after the current interval
      load(0, 1'b1, 0, 1'b0, t);
      wait_tick(20, g);
      check(1 + g == 3, "R7 last interval completes", 1 + g, 3);
      wait_tick(50, g);
      check(g == -1, "R7 no further ticks", g, -1);

      // R8: fraction loaded alone, integer retained
      load(6, 1'b1, 0, 1'b1, t);
      wait_tick(20, g);
      check(g == 7, "R8 start", g, 7);
      load(0, 1'b0, 32, 1'b1, t);
      wait_tick(20, g);
      check(1 + g == 6, "R8 running interval", 1 + g, 6);
      for (int k = 0; k < 4; k++) begin
         expv = (k % 2 == 0) ? 6 : 7;
         wait_tick(20, g);
         check(g == expv, "R8 alternating gap", g, expv);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule